// File: doc/BRIEF.md
# Iterative Frame Processing Sequencer

This block steps one image frame through a multi-pass filter. It sits between an input frame buffer, a single-ported working memory and an output frame buffer. It waits in an idle state until the input side signals that a complete frame is ready. It then copies the frame into the working memory. Next it sweeps every pixel of that memory once per pass, for a pass count programmed on an input port. Finally it copies the result out to the output buffer and flags completion. The filter arithmetic, the widening pre-stage and the video timing sit outside the block. They see only the addresses, strobes and the per-pixel filter step pulse that the block drives.

The working memory has a single port and runs on the same fast clock as this block. One processing cycle is two fast clocks: a read phase (phase 0) followed by a write phase (phase 1). A phase bit toggles on every clock. All state moves and counter steps happen on the clock edge that ends phase 1.

The states and their transitions are as follows:
- S_IDLE → S_LOAD when a frame request is present. The request is either the live flag or one latched earlier.
- S_LOAD → S_SWEEP when the pixel counter wraps.
- S_SWEEP → S_SWEEP on a wrap that is not the last pass.
- S_SWEEP → S_UNLOAD on the wrap that completes the last pass.
- S_UNLOAD → S_FINISH on a wrap.
- S_FINISH → S_IDLE after one processing cycle.

The default frame is 128 by 128 pixels, giving a 14-bit pixel address.

Top module: `frame_iter_seq`

## Requirements
- R1: A synchronous reset, at any time, forces the idle state: busy and done low, the phase bit 0, the pixel and pass counters 0, and every strobe low.
- R2: `mem_phase` toggles on every clock. `wm_rd`, `ibuf_rd` and `filt_step` are never high when `mem_phase` is 1. `wm_wr` and `obuf_wr` are never high when `mem_phase` is 0. A state change is first seen in a cycle with `mem_phase` = 0.
- R3: Without a `new_frame` pulse the block stays idle with busy low. A one-cycle `new_frame` pulse while idle makes busy rise within three clocks.
- R4: In the load state, for each pixel index k from 0 to N-1 in ascending order (N = pixel count), there is one processing cycle. In phase 0 it drives `ibuf_rd` = 1 with `ibuf_addr` = k. In phase 1 it drives `wm_wr` = 1 with `wm_addr` = k.
- R5: In the sweep state, each pass visits k = 0 to N-1 in order. Phase 0 drives `wm_rd` = 1 with `wm_addr` = k. Phase 1 drives `wm_wr` = 1 and `filt_step` = 1 at the same address k. `pix_cnt` equals k. `iter_cnt` equals the number of completed passes.
- R6: The pass count E is taken from `iter_cfg` when the frame starts, and a value of 0 counts as 1. Changing `iter_cfg` during a run does not change that run's length. The frame occupies exactly 2·(2N + N·E + 1) clocks of busy.
- R7: In the unload state, for k = 0 to N-1 in order, phase 0 drives `wm_rd` = 1 with `wm_addr` = k. Phase 1 drives `obuf_wr` = 1 with `obuf_addr` = k. `iter_cnt` holds E.
- R8: `done` is high for exactly one processing cycle (two clocks) at the end of a frame, with busy still high. Then the block returns to idle with busy low.
- R9: A `new_frame` pulse that arrives while busy is latched. After done, the block spends exactly one processing cycle (two clocks) idle and then starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the processing rate) |
| rst | input | 1 | Synchronous reset, active high |
| new_frame | input | 1 | Pulse: a full frame waits in the input buffer |
| iter_cfg | input | ITER_W | Programmed pass count (0 acts as 1) |
| mem_phase | output | 1 | 0 = read phase, 1 = write phase |
| wm_addr | output | PIX_W | Working memory address |
| wm_rd | output | 1 | Working memory read strobe |
| wm_wr | output | 1 | Working memory write strobe |
| ibuf_addr | output | PIX_W | Input buffer address |
| ibuf_rd | output | 1 | Input buffer read strobe |
| obuf_addr | output | PIX_W | Output buffer address |
| obuf_wr | output | 1 | Output buffer write strobe |
| filt_step | output | 1 | Filter advances one pixel |
| pix_cnt | output | PIX_W | Current pixel index |
| iter_cnt | output | ITER_W | Completed passes in this frame |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Final processing cycle of a frame |

## Verification
Two events can land in the same processing cycle: a fresh frame request and the close of the current frame. The bench raises `new_frame` while the block is still busy, deep inside the sweep. This forces the request latch to carry the request across the FINISH-to-IDLE edge. The bench then judges by arithmetic that busy drops for exactly two clocks and rises again in a read phase. The bench also compares every clock of every frame against an expected schedule computed from N and E. The pass counts used are 1, 2, 3, 0 (treated as 1) and 5, and one run has its configuration changed mid-frame.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LOAD   = 3'd1,
        S_SWEEP  = 3'd2,
        S_UNLOAD = 3'd3,
        S_FINISH = 3'd4
    } seq_state_t;

    function automatic logic is_moving(input seq_state_t s);
        return (s == S_LOAD) || (s == S_SWEEP) || (s == S_UNLOAD);
    endfunction

endpackage

// File: rtl/fseq_phase_gen.sv
module fseq_phase_gen (
    input  logic clk,
    input  logic rst,
    output logic phase
);

    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phase != $past(phase))); // R2

endmodule

// File: rtl/fseq_sweep_cnt.sv
module fseq_sweep_cnt #(
    parameter int PIX_W  = 14,
    parameter int ITER_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_step,
    input  logic              iter_step,
    input  logic              iter_clr,
    output logic [PIX_W-1:0]  pix,
    output logic [ITER_W-1:0] iter,
    output logic              wrap
);

    localparam logic [PIX_W-1:0] PIX_LAST = {PIX_W{1'b1}};

    assign wrap = pix_step && (pix == PIX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= '0;
        end else if (pix_step) begin
            pix <= (pix == PIX_LAST) ? '0 : pix + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || iter_clr) begin
            iter <= '0;
        end else if (iter_step && wrap) begin
            iter <= iter + 1'b1;
        end
    end

    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pix_step && pix == PIX_LAST) |=> (pix == '0)); // R5

    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_step |=> (pix == $past(pix))); // R2

endmodule

// File: rtl/fseq_fsm.sv
module fseq_fsm
    import fseq_pkg::*;
#(
    parameter int ITER_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase,
    input  logic              new_frame,
    input  logic [ITER_W-1:0] iter_cfg,
    input  logic              wrap,
    input  logic [ITER_W-1:0] iter,
    output seq_state_t        state,
    output logic              pix_step,
    output logic              iter_step,
    output logic              iter_clr,
    output logic              busy,
    output logic              done,
    output logic              wm_rd,
    output logic              wm_wr,
    output logic              ibuf_rd,
    output logic              obuf_wr,
    output logic              filt_step
);

    seq_state_t        nxt;
    logic              pending;
    logic              go;
    logic              leave_idle;
    logic [ITER_W-1:0] eff_cfg;
    logic              last_pass;

    assign go         = pending || new_frame;
    assign leave_idle = phase && (state == S_IDLE) && go;
    assign last_pass  = ({1'b0, iter} + 1'b1) >= {1'b0, eff_cfg};

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (go)                nxt = S_LOAD;
            S_LOAD:   if (wrap)              nxt = S_SWEEP;
            S_SWEEP:  if (wrap && last_pass) nxt = S_UNLOAD;
            S_UNLOAD: if (wrap)              nxt = S_FINISH;
            S_FINISH:                        nxt = S_IDLE;
            default:                         nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            pending <= 1'b0;
            eff_cfg <= {{(ITER_W-1){1'b0}}, 1'b1};
        end else begin
            if (phase) state <= nxt;
            if (leave_idle) begin
                pending <= 1'b0;
                eff_cfg <= (iter_cfg == '0) ? {{(ITER_W-1){1'b0}}, 1'b1} : iter_cfg;
            end else begin
                pending <= pending || new_frame;
            end
        end
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        wm_rd     = 1'b0;
        wm_wr     = 1'b0;
        ibuf_rd   = 1'b0;
        obuf_wr   = 1'b0;
        filt_step = 1'b0;
        iter_clr  = 1'b0;
        iter_step = 1'b0;
        pix_step  = phase && is_moving(state);
        unique case (state)
            S_IDLE: begin
                iter_clr = 1'b1;
            end
            S_LOAD: begin
                busy    = 1'b1;
                ibuf_rd = ~phase;
                wm_wr   = phase;
            end
            S_SWEEP: begin
                busy      = 1'b1;
                wm_rd     = ~phase;
                wm_wr     = phase;
                filt_step = phase;
                iter_step = 1'b1;
            end
            S_UNLOAD: begin
                busy    = 1'b1;
                wm_rd   = ~phase;
                obuf_wr = phase;
            end
            S_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    AST_STATE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> !phase); // R2

    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == S_SWEEP) |-> (iter < eff_cfg)); // R6

    AST_DONE_SHORT: assert property (@(posedge clk) disable iff (rst)
        (done && phase) |=> !done); // R8

    AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (rst)
        (new_frame && state != S_IDLE) |=> pending); // R9

endmodule

// File: rtl/frame_iter_seq.sv
module frame_iter_seq
    import fseq_pkg::*;
#(
    parameter int ROW_LOG2 = 7,
    parameter int COL_LOG2 = 7,
    parameter int ITER_W   = 8,
    localparam int PIX_W   = ROW_LOG2 + COL_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              new_frame,
    input  logic [ITER_W-1:0] iter_cfg,
    output logic              mem_phase,
    output logic [PIX_W-1:0]  wm_addr,
    output logic              wm_rd,
    output logic              wm_wr,
    output logic [PIX_W-1:0]  ibuf_addr,
    output logic              ibuf_rd,
    output logic [PIX_W-1:0]  obuf_addr,
    output logic              obuf_wr,
    output logic              filt_step,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [ITER_W-1:0] iter_cnt,
    output logic              busy,
    output logic              done
);

    seq_state_t state;
    logic       pix_step;
    logic       iter_step;
    logic       iter_clr;
    logic       wrap;

    fseq_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (mem_phase)
    );

    fseq_sweep_cnt #(.PIX_W(PIX_W), .ITER_W(ITER_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .pix_step  (pix_step),
        .iter_step (iter_step),
        .iter_clr  (iter_clr),
        .pix       (pix_cnt),
        .iter      (iter_cnt),
        .wrap      (wrap)
    );

    fseq_fsm #(.ITER_W(ITER_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .phase     (mem_phase),
        .new_frame (new_frame),
        .iter_cfg  (iter_cfg),
        .wrap      (wrap),
        .iter      (iter_cnt),
        .state     (state),
        .pix_step  (pix_step),
        .iter_step (iter_step),
        .iter_clr  (iter_clr),
        .busy      (busy),
        .done      (done),
        .wm_rd     (wm_rd),
        .wm_wr     (wm_wr),
        .ibuf_rd   (ibuf_rd),
        .obuf_wr   (obuf_wr),
        .filt_step (filt_step)
    );

    assign wm_addr   = pix_cnt;
    assign ibuf_addr = pix_cnt;
    assign obuf_addr = pix_cnt;

    AST_RD_PHASE0: assert property (@(posedge clk) disable iff (rst)
        (wm_rd || ibuf_rd) |-> !mem_phase); // R2

    AST_WR_PHASE1: assert property (@(posedge clk) disable iff (rst)
        (wm_wr || obuf_wr) |-> mem_phase); // R2

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(wm_rd || wm_wr || ibuf_rd || obuf_wr || filt_step)); // R3

endmodule

// File: tb/test_frame_iter_seq.sv
module test_frame_iter_seq;

    localparam int RL = 2;
    localparam int CL = 2;
    localparam int IW = 8;
    localparam int PW = RL + CL;
    localparam int N  = 1 << PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          new_frame = 1'b0;
    logic [IW-1:0] iter_cfg = '0;
    logic          mem_phase, wm_rd, wm_wr, ibuf_rd, obuf_wr, filt_step, busy, done;
    logic [PW-1:0] wm_addr, ibuf_addr, obuf_addr, pix_cnt;
    logic [IW-1:0] iter_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    frame_iter_seq #(.ROW_LOG2(RL), .COL_LOG2(CL), .ITER_W(IW)) i_frame_iter_seq (
        .clk(clk), .rst(rst), .new_frame(new_frame), .iter_cfg(iter_cfg),
        .mem_phase(mem_phase), .wm_addr(wm_addr), .wm_rd(wm_rd), .wm_wr(wm_wr),
        .ibuf_addr(ibuf_addr), .ibuf_rd(ibuf_rd), .obuf_addr(obuf_addr),
        .obuf_wr(obuf_wr), .filt_step(filt_step), .pix_cnt(pix_cnt),
        .iter_cnt(iter_cnt), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic wait_start(output int n);
        n = 0;
        while (!busy && n < 10) begin
            @(negedge clk);
            n++;
        end
    endtask

    // cycle-by-cycle compare of a frame; t = 0 is the first busy cycle
    task automatic run_frame(input int e, input int pend_at, input int cfg_at);
        int total = 2 * (2 * N + N * e + 1);
        for (int t = 0; t < total; t++) begin
            int  p  = t / 2;
            bit  ph = bit'(t % 2);
            int  st, adr, it;
            logic [7:0] ef, af;
            if (p < N)                  begin st = 1; adr = p;               it = 0;           end
            else if (p < N + N * e)     begin st = 2; adr = (p - N) % N;     it = (p - N) / N; end
            else if (p < 2 * N + N * e) begin st = 3; adr = p - N - N * e;   it = e;           end
            else                        begin st = 4; adr = 0;               it = e;           end
            ef = {1'b1, st == 4, ph,
                  !ph && (st == 2 || st == 3), ph && (st == 1 || st == 2),
                  !ph && st == 1, ph && st == 3, ph && st == 2};
            af = {busy, done, mem_phase, wm_rd, wm_wr, ibuf_rd, obuf_wr, filt_step};
            case (st)
                1: check(af == ef, "R4 strobes", af, ef);
                2: check(af == ef, "R5 strobes", af, ef);
                3: check(af == ef, "R7 strobes", af, ef);
                default: check(af == ef, "R8 strobes", af, ef);
            endcase
            if (t == 0) check(mem_phase == 1'b0, "R2 start phase", mem_phase, 0);
            if (st != 4) begin
                check(wm_addr == PW'(adr) && pix_cnt == PW'(adr), "R5 address", wm_addr, adr);
                if (st == 1) check(ibuf_addr == PW'(adr), "R4 ibuf addr", ibuf_addr, adr);
                if (st == 3) check(obuf_addr == PW'(adr), "R7 obuf addr", obuf_addr, adr);
            end
            check(iter_cnt == IW'(it), "R6 pass count", iter_cnt, it);
            if (t == pend_at) new_frame = 1'b1;
            if (t == cfg_at)  iter_cfg  = 8'd7;
            @(negedge clk);
            new_frame = 1'b0;
        end
    endtask

    task automatic frame(input int cfg, input int e, input int pend_at, input int cfg_at);
        int n;
        iter_cfg  = IW'(cfg);
        new_frame = 1'b1;
        @(negedge clk);
        new_frame = 1'b0;
        wait_start(n);
        check(busy == 1'b1 && n <= 2, "R3 start", n, 2);
        run_frame(e, pend_at, cfg_at);
        check(busy == 1'b0, "R8 back to idle", busy, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy, done, mem_phase, wm_rd, wm_wr, ibuf_rd, obuf_wr, filt_step} == 8'h0,
              "R1 reset outputs", busy, 0);
        check(pix_cnt == 0 && iter_cnt == 0, "R1 reset counters", pix_cnt, 0);
        rst = 1'b0;
        // R3 no request keeps idle
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(busy == 1'b0, "R3 idle hold", busy, 0);
        end
        frame(1, 1, -1, -1);
        repeat (3) @(negedge clk);
        frame(2, 2, -1, -1);
        @(negedge clk);
        frame(3, 3, -1, 10);      // R6: cfg changed mid-run, length stays 3
        @(negedge clk);
        frame(0, 1, -1, -1);      // R6: zero acts as one
        repeat (2) @(negedge clk);
        frame(5, 5, -1, -1);
        @(negedge clk);
        // R9: request while busy, serviced after finish
        iter_cfg = 8'd2;
        new_frame = 1'b1;
        @(negedge clk);
        new_frame = 1'b0;
        wait_start(n);
        run_frame(2, 70, -1);
        check(busy == 1'b0, "R9 idle gap 1", busy, 0);
        @(negedge clk);
        check(busy == 1'b0, "R9 idle gap 2", busy, 0);
        @(negedge clk);
        check(busy == 1'b1, "R9 restart", busy, 1);
        iter_cfg = 8'd2;
        run_frame(2, -1, -1);
        // R1 mid-run reset
        frame(4, 4, -1, -1);
        iter_cfg = 8'd4;
        new_frame = 1'b1;
        @(negedge clk);
        new_frame = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check({busy, done, mem_phase} == 3'b0, "R1 mid-run reset", busy, 0);
        check(pix_cnt == 0 && iter_cnt == 0, "R1 mid-run counters", pix_cnt, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R1 stays idle", busy, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule